// File: doc/BRIEF.md
# Mailbox Command Issue Sequencer

This block is a hardware master that carries one command at a time through a doorbell-style mailbox reached over a simple register port. A local requester hands it an opcode, an input length in bytes, the size of its own receive buffer, and then streams the input payload as 64-bit words. The sequencer first confirms the mailbox is free, then writes the command word and any payload words, and only then rings the doorbell. It then polls the doorbell under a cycle-count timeout, reads back the return code and the device's output length, and streams out a clamped number of output payload words.

The state machine has twelve states. IDLE waits for a request. CHECK reads the control register: doorbell set takes the BUSY exit to DONE, clear goes to CMD. CMD writes the command word, then goes to PGET when the input length is non-zero, else to RING. PGET takes one input word, PPUT writes it to the next payload slot and goes back to PGET until the last word, then to RING. RING sets the doorbell and goes to POLL. POLL reads the control register: clear goes to STAT; still set with the timer expired goes to RECHK; otherwise it stays in POLL. RECHK reads the control register once more: clear goes to STAT, set takes the TIMEOUT exit to DONE. STAT reads the return code: non-zero goes to DONE, zero goes to OLEN. OLEN reads the output length and computes the clamped count: zero goes to DONE, otherwise it goes to ORD. ORD reads one payload word per access until the count is covered, then goes to DONE. DONE pulses the completion outputs for one cycle and returns to IDLE.

Register layout: control at offset 0x000 (bit 0 is the doorbell), command at 0x008 (opcode in bits 15:0, payload length in bits 52:32), status at 0x010 (return code in bits 15:0), and payload words at 0x100 + 8·i. All offsets are parameters.

Top module: `mbox_issue_seq`

## Requirements
- R1: `req_ready` is high only in IDLE, and a request is taken on a cycle where `req_valid` and `req_ready` are both high.
- R2: The first register access of every command reads the control register. If bit 0 is set, the command ends with result code 1 (busy), and no register write takes place.
- R3: The first write is to the command register, with the opcode in bits 15:0 and the input length in bytes in bits 52:32.
- R4: When the input length is non-zero, ceil(len/8) payload words are written in stream order to payload base + 8·i, all after the command write. When the length is zero, no payload write is made.
- R5: The last write of a command sets bit 0 of the control register, and it follows all command and payload writes.
- R6: The control register is polled until bit 0 reads clear. Once `TIMEOUT_CYC` polling cycles have passed with the bit still set, one more read is made. Result code 2 (timeout) is reported only if that read still shows the bit set; otherwise the command goes on normally.
- R7: After completion, the status register is read. A non-zero return code ends the command with result 0, the code on `done_rc`, an output length of 0, and no payload reads.
- R8: On success, the output length in bits 52:32 of the command register is read. The count reported on `done_out_len` is the minimum of the requester's buffer size, `PAYLOAD_BYTES` and the device length, which makes it 0 if either of the latter two lengths is 0.
- R9: ceil(count/8) payload words are read from payload base + 8·i in order. Each is presented on `out_data` with a one-cycle `out_valid`, and nothing is streamed when the count is 0.
- R10: `done` is a one-cycle pulse per command. `done_status` is 0 for ok, 1 for busy and 2 for timeout, and never 3.
- R11: Once `reg_req` is raised, it and the address, write-enable and write data stay unchanged until `reg_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_opcode | input | 16 | Command opcode |
| req_in_len | input | 21 | Input payload length in bytes |
| req_out_cap | input | 21 | Requester receive buffer size in bytes |
| in_valid | input | 1 | Input payload word present |
| in_ready | output | 1 | Input payload word taken |
| in_data | input | 64 | Input payload word |
| out_valid | output | 1 | Output payload word valid (one cycle) |
| out_data | output | 64 | Output payload word |
| done | output | 1 | Command finished (one-cycle pulse) |
| done_status | output | 2 | 0 ok, 1 busy, 2 timeout |
| done_rc | output | 16 | Device return code |
| done_out_len | output | 21 | Output bytes delivered |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | ADDR_W | Register byte offset |
| reg_wdata | output | 64 | Write data |
| reg_ack | input | 1 | Access completes this cycle |
| reg_rdata | input | 64 | Read data, valid with `reg_ack` |

## Verification
The assertions assume the register side acknowledges only while `reg_req` is high and returns read data in the same cycle as the acknowledge. They also assume the requester does not raise a request while a command is still in flight. The bench's mailbox model acknowledges one cycle after a request, and in one mode it holds back an acknowledge for much longer than the timeout. It returns data only together with the acknowledge. The bench issues each request only when it sees `req_ready`, so the stimulus stays inside those assumptions while the timeout, re-check, busy and clamp paths are all driven.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

    localparam int OP_W        = 16;
    localparam int LEN_W       = 21;
    localparam int RC_W        = 16;
    localparam int DATA_W      = 64;
    localparam int CMD_LEN_LSB = 32;
    localparam int DB_BIT      = 0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_CMD,
        S_PGET,
        S_PPUT,
        S_RING,
        S_POLL,
        S_RECHK,
        S_STAT,
        S_OLEN,
        S_ORD,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_BUSY    = 2'd1,
        RES_TIMEOUT = 2'd2
    } seq_result_e;

endpackage

// File: rtl/mbox_len_clamp.sv
module mbox_len_clamp #(
    parameter int LEN_W = 21,
    parameter int LIMIT = 256
) (
    input  logic [LEN_W-1:0] want_len,
    input  logic [LEN_W-1:0] dev_len,
    output logic [LEN_W-1:0] xfer_len
);
    localparam logic [LEN_W-1:0] LIM = LEN_W'(LIMIT);

    logic [LEN_W-1:0] lesser;

    always_comb begin
        lesser   = (want_len < dev_len) ? want_len : dev_len;
        xfer_len = (lesser < LIM) ? lesser : LIM;
    end

endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int LIMIT = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIM);

    // R6: expiry is only reached by counting polling cycles
    assert_expiry_from_poll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(run));

    // R6: a clear always restarts the window
    assert_clear_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);

endmodule

// File: rtl/mbox_issue_seq.sv
module mbox_issue_seq
    import mbox_seq_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int PAYLOAD_BYTES = 256,
    parameter int TIMEOUT_CYC   = 200_000_000,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 'h000,
    parameter logic [ADDR_W-1:0] OFS_CMD  = 'h008,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'h010,
    parameter logic [ADDR_W-1:0] OFS_PAY  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_opcode,
    input  logic [20:0]       req_in_len,
    input  logic [20:0]       req_out_cap,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [63:0]       in_data,
    output logic              out_valid,
    output logic [63:0]       out_data,
    output logic              done,
    output logic [1:0]        done_status,
    output logic [15:0]       done_rc,
    output logic [20:0]       done_out_len,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [63:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [63:0]       reg_rdata
);
    localparam int IDX_W = LEN_W - 2;

    seq_state_e  state_q, state_d;
    seq_result_e res_q;

    logic [OP_W-1:0]   op_q;
    logic [LEN_W-1:0]  in_len_q;
    logic [LEN_W-1:0]  cap_q;
    logic [LEN_W-1:0]  out_len_q;
    logic [RC_W-1:0]   rc_q;
    logic [DATA_W-1:0] wbuf_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  out_words_q;
    logic [IDX_W-1:0]  in_words;
    logic [IDX_W-1:0]  xfer_words;
    logic [LEN_W-1:0]  xfer_len;
    logic [LEN_W-1:0]  dev_len;
    logic [ADDR_W-1:0] pay_addr;
    logic              door_set;
    logic              tmo_hit;

    assign door_set   = reg_rdata[DB_BIT];
    assign dev_len    = reg_rdata[CMD_LEN_LSB +: LEN_W];
    assign in_words   = IDX_W'(({1'b0, in_len_q} + (LEN_W + 1)'(7)) >> 3);
    assign xfer_words = IDX_W'(({1'b0, xfer_len} + (LEN_W + 1)'(7)) >> 3);
    assign pay_addr   = OFS_PAY + ADDR_W'({idx_q, 3'b000});

    mbox_len_clamp #(
        .LEN_W (LEN_W),
        .LIMIT (PAYLOAD_BYTES)
    ) u_clamp (
        .want_len (cap_q),
        .dev_len  (dev_len),
        .xfer_len (xfer_len)
    );

    mbox_poll_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == S_RING),
        .run     (state_q == S_POLL),
        .expired (tmo_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_CHECK;
            S_CHECK: if (reg_ack) state_d = door_set ? S_DONE : S_CMD;
            S_CMD:   if (reg_ack) state_d = (in_len_q != '0) ? S_PGET : S_RING;
            S_PGET:  if (in_valid) state_d = S_PPUT;
            S_PPUT:  if (reg_ack) state_d = (idx_q + 1'b1 == in_words) ? S_RING : S_PGET;
            S_RING:  if (reg_ack) state_d = S_POLL;
            S_POLL:  if (reg_ack) state_d = !door_set ? S_STAT : (tmo_hit ? S_RECHK : S_POLL);
            S_RECHK: if (reg_ack) state_d = door_set ? S_DONE : S_STAT;
            S_STAT:  if (reg_ack) state_d = (reg_rdata[RC_W-1:0] != '0) ? S_DONE : S_OLEN;
            S_OLEN:  if (reg_ack) state_d = (xfer_len == '0) ? S_DONE : S_ORD;
            S_ORD:   if (reg_ack) state_d = (idx_q + 1'b1 == out_words_q) ? S_DONE : S_ORD;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= '0;
            in_len_q    <= '0;
            cap_q       <= '0;
            out_len_q   <= '0;
            rc_q        <= '0;
            wbuf_q      <= '0;
            idx_q       <= '0;
            out_words_q <= '0;
            res_q       <= RES_OK;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                op_q      <= req_opcode;
                in_len_q  <= req_in_len;
                cap_q     <= req_out_cap;
                out_len_q <= '0;
                rc_q      <= '0;
                idx_q     <= '0;
                res_q     <= RES_OK;
            end
            if (state_q == S_CHECK && reg_ack && door_set) res_q <= RES_BUSY;
            if (state_q == S_PGET && in_valid) wbuf_q <= in_data;
            if (state_q == S_PPUT && reg_ack) idx_q <= idx_q + 1'b1;
            if (state_q == S_RECHK && reg_ack && door_set) res_q <= RES_TIMEOUT;
            if (state_q == S_STAT && reg_ack) rc_q <= reg_rdata[RC_W-1:0];
            if (state_q == S_OLEN && reg_ack) begin
                out_len_q   <= xfer_len;
                out_words_q <= xfer_words;
                idx_q       <= '0;
            end
            if (state_q == S_ORD && reg_ack) idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        in_ready  = 1'b0;
        unique case (state_q)
            S_CHECK, S_POLL, S_RECHK: begin
                reg_req  = 1'b1;
                reg_addr = OFS_CTRL;
            end
            S_CMD: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = OFS_CMD;
                reg_wdata = DATA_W'(op_q) | (DATA_W'(in_len_q) << CMD_LEN_LSB);
            end
            S_PGET: in_ready = 1'b1;
            S_PPUT: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = pay_addr;
                reg_wdata = wbuf_q;
            end
            S_RING: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = OFS_CTRL;
                reg_wdata = DATA_W'(1) << DB_BIT;
            end
            S_STAT: begin
                reg_req  = 1'b1;
                reg_addr = OFS_STAT;
            end
            S_OLEN: begin
                reg_req  = 1'b1;
                reg_addr = OFS_CMD;
            end
            S_ORD: begin
                reg_req  = 1'b1;
                reg_addr = pay_addr;
            end
            default: ;
        endcase
    end

    assign req_ready    = (state_q == S_IDLE);
    assign out_valid    = (state_q == S_ORD) && reg_ack;
    assign out_data     = reg_rdata;
    assign done         = (state_q == S_DONE);
    assign done_status  = res_q;
    assign done_rc      = rc_q;
    assign done_out_len = out_len_q;

    // R11: an access is held unchanged until acknowledged
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: only the three defined result codes
    assert_done_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_status != 2'd3));

    // R1: no bus or stream activity while idle
    assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!reg_req && !out_valid && !in_ready));

    // R8: the reported count never exceeds the buffer or the mailbox size
    assert_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_out_len <= cap_q && 32'(done_out_len) <= PAYLOAD_BYTES));

    // R7: a failing return code carries no output
    assert_no_len_on_rc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_rc != '0) |-> (done_out_len == '0));

    // R9: output words come only from read accesses
    assert_stream_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (reg_req && !reg_we));

endmodule

// File: tb/mbox_issue_seq_tb.sv
module mbox_issue_seq_tb;
    localparam int AW    = 12;
    localparam int TMO   = 40;
    localparam int PB    = 256;
    localparam int STALL = 60;
    localparam logic [AW-1:0] A_CTRL = 12'h000;
    localparam logic [AW-1:0] A_CMD  = 12'h008;
    localparam logic [AW-1:0] A_STAT = 12'h010;
    localparam logic [AW-1:0] A_PAY  = 12'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [15:0]   req_opcode = '0;
    logic [20:0]   req_in_len = '0;
    logic [20:0]   req_out_cap = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [63:0]   in_data = '0;
    logic          out_valid;
    logic [63:0]   out_data;
    logic          done;
    logic [1:0]    done_status;
    logic [15:0]   done_rc;
    logic [20:0]   done_out_len;
    logic          reg_req;
    logic          reg_we;
    logic [AW-1:0] reg_addr;
    logic [63:0]   reg_wdata;
    logic          reg_ack;
    logic [63:0]   reg_rdata;

    mbox_issue_seq #(
        .ADDR_W        (AW),
        .PAYLOAD_BYTES (PB),
        .TIMEOUT_CYC   (TMO),
        .OFS_CTRL      (A_CTRL),
        .OFS_CMD       (A_CMD),
        .OFS_STAT      (A_STAT),
        .OFS_PAY       (A_PAY)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_opcode (req_opcode),
        .req_in_len (req_in_len), .req_out_cap (req_out_cap),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .out_valid (out_valid), .out_data (out_data),
        .done (done), .done_status (done_status), .done_rc (done_rc), .done_out_len (done_out_len),
        .reg_req (reg_req), .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_ack (reg_ack), .reg_rdata (reg_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ---------------- mailbox model ----------------
    int          dmode = 0;   // 0 normal, 1 never clears, 2 late clear, 3 already busy
    logic [15:0] d_rc = '0;
    logic [20:0] d_len = '0;
    logic [63:0] d_seed = '0;
    bit          rung = 0;
    bit          stalled = 0;
    int          polls = 0;
    int          wait_cnt = 0;
    int          n_rd = 0;
    int          n_pay_rd = 0;
    logic [AW-1:0] wl_a[$];
    logic [63:0]   wl_d[$];
    logic        d_ack = 1'b0;
    logic [63:0] d_rdata = '0;

    assign reg_ack   = d_ack;
    assign reg_rdata = d_rdata;

    function automatic logic [63:0] oword(input logic [63:0] seed, input int i);
        return seed ^ (64'h0101_0000_0000_0000 * 64'(i)) ^ 64'(i);
    endfunction

    function automatic logic [63:0] iword(input logic [15:0] op, input int i);
        return {op, 16'h5A00, 32'(i)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            d_ack <= 1'b0;
        end else if (d_ack) begin
            d_ack <= 1'b0;
        end else if (reg_req) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else if (dmode == 2 && rung && polls == 0 && !stalled && !reg_we && reg_addr == A_CTRL) begin
                stalled  = 1;
                wait_cnt = STALL;
            end else begin
                d_ack <= 1'b1;
                if (reg_we) begin
                    wl_a.push_back(reg_addr);
                    wl_d.push_back(reg_wdata);
                    if (reg_addr == A_CTRL && reg_wdata[0]) begin
                        rung  = 1;
                        polls = 0;
                    end
                end else begin
                    n_rd++;
                    if (reg_addr == A_CTRL) begin
                        if (!rung) d_rdata <= (dmode == 3) ? 64'd1 : 64'd0;
                        else begin
                            polls++;
                            d_rdata <= {63'd0, (dmode == 1) || (dmode == 0 && polls <= 2) || (dmode == 2 && polls == 1)};
                        end
                    end else if (reg_addr == A_STAT) d_rdata <= {48'd0, d_rc};
                    else if (reg_addr == A_CMD) d_rdata <= {11'd0, d_len, 32'd0};
                    else if (reg_addr >= A_PAY) begin
                        n_pay_rd++;
                        d_rdata <= oword(d_seed, int'((reg_addr - A_PAY) >> 3));
                    end else d_rdata <= '0;
                end
            end
        end
    end

    // ---------------- input payload feeder ----------------
    logic [63:0] feed_q[$];
    initial begin
        forever begin
            bit took;
            @(negedge clk);
            took = in_valid && in_ready;
            @(posedge clk);
            #1;
            if (took && feed_q.size() > 0) void'(feed_q.pop_front());
            in_valid = (feed_q.size() > 0);
            if (feed_q.size() > 0) in_data = feed_q[0];
        end
    end

    // ---------------- per-clock reference comparison ----------------
    logic [63:0] exp_q[$];
    bit  exp_ready = 1;
    bit  done_prev = 0;
    bit  hold_prev = 0;
    logic [AW-1:0] addr_prev = '0;
    int  ready_mis = 0;
    int  pulse_mis = 0;
    int  out_mis = 0;
    int  hold_mis = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ready !== exp_ready) ready_mis++;
            if (done && done_prev) pulse_mis++;
            done_prev = done;
            if (hold_prev && !(reg_req && reg_addr == addr_prev)) hold_mis++;
            hold_prev = reg_req && !reg_ack;
            addr_prev = reg_addr;
            if (out_valid) begin
                if (exp_q.size() == 0) out_mis++;
                else if (out_data !== exp_q.pop_front()) out_mis++;
            end
            if (req_valid && req_ready) exp_ready = 0;
            else if (done) exp_ready = 1;
        end
    end

    // ---------------- one command ----------------
    task automatic run_cmd(input int mode, input logic [15:0] op, input int in_len, input int cap,
                           input int dlen, input logic [15:0] rc,
                           input int exp_status, input int exp_len, input int exp_rc, input string name);
        int nw_in;
        int nw_out;
        int cyc;
        int n_wr;
        dmode = mode; d_rc = rc; d_len = 21'(dlen); d_seed = {op, 48'h0000_1357_9BDF};
        rung = 0; stalled = 0; polls = 0; wait_cnt = 0; n_rd = 0; n_pay_rd = 0;
        wl_a.delete(); wl_d.delete(); out_mis = 0; exp_q.delete();
        nw_in  = (in_len + 7) / 8;
        nw_out = (exp_len + 7) / 8;
        for (int i = 0; i < nw_out; i++) exp_q.push_back(oword(d_seed, i));
        for (int i = 0; i < nw_in; i++) feed_q.push_back(iword(op, i));
        @(posedge clk); #1;
        req_valid = 1'b1; req_opcode = op; req_in_len = 21'(in_len); req_out_cap = 21'(cap);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!done && cyc < 5000);
        chk(done, {name, " R10 completion seen"}, longint'(done), 1);
        chk(done_status == 2'(exp_status), {name, " R10 result code"}, longint'(done_status), exp_status);
        chk(done_rc == 16'(exp_rc), {name, " R7 return code"}, longint'(done_rc), exp_rc);
        chk(done_out_len == 21'(exp_len), {name, " R8 clamped length"}, longint'(done_out_len), exp_len);
        feed_q.delete();
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_mis == 0 && exp_q.size() == 0, {name, " R9 output stream"}, out_mis + exp_q.size(), 0);
        chk(n_pay_rd == nw_out, {name, " R9 payload reads"}, n_pay_rd, nw_out);
        n_wr = wl_a.size();
        if (exp_status == 1) begin
            chk(n_wr == 0, {name, " R2 no write when busy"}, n_wr, 0);
            chk(n_rd == 1, {name, " R2 single control read"}, n_rd, 1);
        end else begin
            chk(n_wr == nw_in + 2, {name, " R4 write count"}, n_wr, nw_in + 2);
            if (n_wr == nw_in + 2) begin
                chk(wl_a[0] == A_CMD && wl_d[0] == {11'd0, 21'(in_len), 16'd0, op},
                    {name, " R3 command word"}, longint'(wl_d[0]), longint'({11'd0, 21'(in_len), 16'd0, op}));
                for (int i = 0; i < nw_in; i++)
                    chk(wl_a[1+i] == A_PAY + AW'(8*i) && wl_d[1+i] == iword(op, i),
                        {name, " R4 payload word"}, longint'(wl_d[1+i]), longint'(iword(op, i)));
                chk(wl_a[n_wr-1] == A_CTRL && wl_d[n_wr-1] == 64'd1, {name, " R5 doorbell last"},
                    longint'(wl_d[n_wr-1]), 1);
            end
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "reset R1 ready", longint'(req_ready), 1);
        chk(done == 1'b0 && reg_req == 1'b0 && in_ready == 1'b0, "reset R10 quiet",
            longint'({done, reg_req, in_ready}), 0);

        run_cmd(0, 16'h0101, 20, 64,        40,        16'h0, 0, 40,  0, "normal");
        run_cmd(0, 16'h0202, 0,  1000,      300,       16'h0, 0, 256, 0, "noinput_sizecap");
        run_cmd(0, 16'h0303, 8,  10,        100,       16'h0, 0, 10,  0, "bufcap");
        run_cmd(0, 16'h0404, 16, 64,        0,         16'h0, 0, 0,   0, "devzero");
        run_cmd(0, 16'h0505, 0,  0,         50,        16'h0, 0, 0,   0, "capzero");
        run_cmd(0, 16'h0606, 8,  64,        40,        16'h5, 0, 0,   5, "rcfail");
        run_cmd(3, 16'h0707, 24, 64,        40,        16'h0, 1, 0,   0, "busy");
        run_cmd(1, 16'h0808, 8,  64,        40,        16'h0, 2, 0,   0, "timeout");
        run_cmd(2, 16'h0909, 8,  64,        24,        16'h0, 0, 24,  0, "late_recheck");
        run_cmd(0, 16'h0A0A, 0,  21'h1FFFFF, 21'h1FFFFF, 16'h0, 0, 256, 0, "oversize");
        run_cmd(0, 16'h0B0B, 1,  64,        1,         16'h0, 0, 1,   0, "onebyte");

        chk(ready_mis == 0, "R1 ready tracking", ready_mis, 0);
        chk(pulse_mis == 0, "R10 single-cycle done", pulse_mis, 0);
        chk(hold_mis == 0, "R11 request held until ack", hold_mis, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule